// File: doc/BRIEF.md
# Per-Pin Interrupt Trigger Detector

This block watches a bank of already-synchronized input pins and raises one combined interrupt request when any of them meets its programmed trigger condition. Every pin has its own control word. A 4-bit trigger code in that word picks one of six conditions: disabled, low level, high level, rising edge, falling edge or either edge. A detected condition sets a sticky per-pin flag. Software finds the flags in one shared status word and clears them by writing ones.

Software reaches the block through a simple register port. A write strobe or a read strobe comes with a byte address and a data word. The port has no back-pressure. A write takes effect at the clock edge that samples it. The data for a read appears on `bus_rdata` one cycle later and stays there until the next read. The interrupt line is registered, so it follows the status flags with one cycle of delay.

Top module: `pin_irq_unit`

## Requirements
- R1: After reset, every trigger code and every status flag is zero, `irq` is low, and all registers read as zero.
- R2: The control word for pin n is at byte address 4·n. The trigger code is held in bits 19:16. A read returns the stored code in those bits and zeros elsewhere, and any other bits written are discarded.
- R3: With code 0x9 (rising), a flag sets at the first clock edge where the pin reads 1 after reading 0 at the previous edge. Holding the pin at 1, or a falling transition, does not set it again.
- R4: With code 0xA (falling), a flag sets at the first edge where the pin reads 0 after reading 1. A rising transition does not set it.
- R5: With code 0xB (either edge), both a rising and a falling transition set the flag.
- R6: With code 0x8 (low level), the flag sets on every edge where the pin is 0, so a clear issued while the pin stays low leaves the flag at 1.
- R7: With code 0xC (high level), the flag sets on every edge where the pin is 1, and never while the pin is 0.
- R8: Code 0x0 and every code not listed in R3–R7 (for example 0x5) never set a flag.
- R9: The status word is at address 0xA0, with bit n belonging to pin n. Writing 1 to a bit clears it, writing 0 leaves it as it was, and writing all ones clears every flag.
- R10: When a trigger condition and a clearing write hit the same bit at the same edge, the flag ends up set.
- R11: `irq` is the OR of all status flags, registered: it equals that OR as it stood one cycle earlier.
- R12: Writing zero to a pin's control word stops new flags for that pin and leaves its current flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NUM_PINS | Synchronized pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: 32 pins, an 8-bit address and a 32-bit data word. At these values the last control word sits at 0x7C, and flag bit 31 fills the top of the status word, so both ends of the address map and of the flag vector are exercised. The 8-bit address also places the status word at 0xA0 with the unmapped gap above the control words. Pins 0, 3, 4, 7, 9, 10 and 31 each carry a different trigger code. One pin is driven to change in the same cycle as a clearing write, which tests the priority of set over clear.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  localparam int TRIG_W = 4;

  typedef enum logic [TRIG_W-1:0] {
    TRG_OFF  = 4'h0,
    TRG_LOW  = 4'h8,
    TRG_RISE = 4'h9,
    TRG_FALL = 4'hA,
    TRG_BOTH = 4'hB,
    TRG_HIGH = 4'hC
  } trig_code_e;

  // Which conditions a code arms.
  typedef struct packed {
    logic lvl_lo;
    logic lvl_hi;
    logic edge_up;
    logic edge_dn;
  } trig_sel_t;

  function automatic trig_sel_t decode_trig(input logic [TRIG_W-1:0] code);
    trig_sel_t s;
    s = '0;
    case (code)
      TRG_LOW:  s.lvl_lo  = 1'b1;
      TRG_HIGH: s.lvl_hi  = 1'b1;
      TRG_RISE: s.edge_up = 1'b1;
      TRG_FALL: s.edge_dn = 1'b1;
      TRG_BOTH: begin
        s.edge_up = 1'b1;
        s.edge_dn = 1'b1;
      end
      default:  s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pin_cfg_bank.sv
module pin_cfg_bank #(
  parameter int NUM_PINS = 32,
  parameter int TRIG_W   = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_PINS-1:0]              wr_sel,
  input  logic [TRIG_W-1:0]                wr_code,
  output logic [NUM_PINS-1:0][TRIG_W-1:0]  codes
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n)
        codes[p] <= '0;
      else if (wr_sel[p])
        codes[p] <= wr_code;
    end
  end

endmodule

// File: rtl/pin_event_det.sv
module pin_event_det
  import pin_irq_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin,
  input  logic [CODE_W-1:0] code,
  output logic              hit
);

  logic      pin_prev;
  trig_sel_t sel;

  always_ff @(posedge clk) begin
    if (!rst_n)
      pin_prev <= 1'b0;
    else
      pin_prev <= pin;
  end

  always_comb begin
    sel = decode_trig(code);
    hit = (sel.lvl_lo  & ~pin)
        | (sel.lvl_hi  &  pin)
        | (sel.edge_up &  pin & ~pin_prev)
        | (sel.edge_dn & ~pin &  pin_prev);
  end

endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] set_vec,
  input  logic [NUM_PINS-1:0] clr_mask,
  output logic [NUM_PINS-1:0] flags,
  output logic                irq
);

  // Set has priority over a clearing write on the same bit.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= (flags & ~clr_mask) | set_vec;
      irq   <= |flags;
    end
  end

endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int TRIG_LSB    = 16,
  parameter int STATUS_ADDR = 'hA0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq
);

  localparam int IDX_W     = ADDR_W - 2;
  localparam int PIN_IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam logic [IDX_W-1:0]  PIN_LIM  = IDX_W'(NUM_PINS);
  localparam logic [ADDR_W-1:0] STAT_ADR = ADDR_W'(STATUS_ADDR);

  logic [IDX_W-1:0]                word_idx;
  logic                            cfg_hit;
  logic                            stat_hit;
  logic [NUM_PINS-1:0]             cfg_wr;
  logic [NUM_PINS-1:0][TRIG_W-1:0] codes;
  logic [NUM_PINS-1:0]             set_vec;
  logic [NUM_PINS-1:0]             clr_mask;
  logic [NUM_PINS-1:0]             flags;
  logic [DATA_W-1:0]               rdata_d;

  // Address decode
  assign word_idx = bus_addr[ADDR_W-1:2];
  assign cfg_hit  = (bus_addr[1:0] == 2'b00) && (word_idx < PIN_LIM);
  assign stat_hit = (bus_addr == STAT_ADR);
  assign clr_mask = (bus_wr && stat_hit) ? bus_wdata[NUM_PINS-1:0] : '0;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_sel
    assign cfg_wr[p] = bus_wr && cfg_hit && (word_idx == IDX_W'(p));
  end

  pin_cfg_bank #(
    .NUM_PINS (NUM_PINS),
    .TRIG_W   (TRIG_W)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sel  (cfg_wr),
    .wr_code (bus_wdata[TRIG_LSB +: TRIG_W]),
    .codes   (codes)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_det
    pin_event_det #(
      .CODE_W (TRIG_W)
    ) u_det (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (pin_in[p]),
      .code  (codes[p]),
      .hit   (set_vec[p])
    );
  end

  flag_bank #(
    .NUM_PINS (NUM_PINS)
  ) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_mask (clr_mask),
    .flags    (flags),
    .irq      (irq)
  );

  // Read path
  always_comb begin
    rdata_d = '0;
    if (cfg_hit)
      rdata_d[TRIG_LSB +: TRIG_W] = codes[word_idx[PIN_IDX_W-1:0]];
    else if (stat_hit)
      rdata_d[NUM_PINS-1:0] = flags;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rdata_d;
  end

endmodule

// File: rtl/pin_irq_unit_chk.sv
module pin_irq_unit_chk #(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] set_vec,
  input logic [NUM_PINS-1:0] clr_mask,
  input logic [NUM_PINS-1:0] flags,
  input logic                irq
);

  AST_IRQ_TRACKS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|flags)); // R11

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flags) & ~$past(clr_mask)) & ~flags) == '0); // R9

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_mask & ~set_vec) & flags) == '0); // R9

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(set_vec) & ~flags) == '0); // R10

endmodule

bind pin_irq_unit pin_irq_unit_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .set_vec  (set_vec),
  .clr_mask (clr_mask),
  .flags    (flags),
  .irq      (irq)
);

// File: tb/pin_irq_unit_test.sv
module pin_irq_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  pin_irq_unit uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in    (pins),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  // Monitor: compare each read result against the scoreboard queue
  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_irq(input logic e, input string t);
    n_tests++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_all();
    bus_write(8'hA0, 32'hFFFF_FFFF);
    idle(2);
  endtask

  initial begin
    #(200000 * 10);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check_irq(1'b0, "R1 irq after reset");
    bus_read(8'h14, 32'h0, "R1 control word");
    bus_read(8'hA0, 32'h0, "R1 status");

    // R2 map and field position
    bus_write(8'h00, 32'h0009_0000);
    bus_write(8'h7C, 32'hFFFA_FFFF);
    bus_read(8'h00, 32'h0009_0000, "R2 pin0 code");
    bus_read(8'h7C, 32'h000A_0000, "R2 pin31 code, other bits dropped");

    // R3 rising on pin 0
    pins[0] = 1'b1;
    idle(1);
    bus_read(8'hA0, 32'h0000_0001, "R3 rise sets");
    check_irq(1'b1, "R11 irq high");
    bus_write(8'hA0, 32'h1);
    idle(2);
    bus_read(8'hA0, 32'h0, "R3 held high no reset");
    pins[0] = 1'b0;
    idle(2);
    bus_read(8'hA0, 32'h0, "R3 fall ignored");
    check_irq(1'b0, "R11 irq low");

    // R4 falling on pin 31
    pins[31] = 1'b1;
    idle(2);
    bus_read(8'hA0, 32'h0, "R4 rise ignored");
    pins[31] = 1'b0;
    idle(1);
    bus_read(8'hA0, 32'h8000_0000, "R4 fall sets");
    // R9 write zero no effect, all ones clears
    bus_write(8'hA0, 32'h0);
    idle(1);
    bus_read(8'hA0, 32'h8000_0000, "R9 write zero keeps");
    bus_write(8'hA0, 32'h7FFF_FFFF);
    idle(1);
    bus_read(8'hA0, 32'h8000_0000, "R9 other bits keep");
    clear_all();
    bus_read(8'hA0, 32'h0, "R9 all ones clears");

    // R5 either edge on pin 7
    bus_write(8'h1C, 32'h000B_0000);
    pins[7] = 1'b1;
    idle(1);
    bus_read(8'hA0, 32'h0000_0080, "R5 rise sets");
    clear_all();
    pins[7] = 1'b0;
    idle(1);
    bus_read(8'hA0, 32'h0000_0080, "R5 fall sets");
    clear_all();

    // R6 low level on pin 3 (pin is low)
    bus_write(8'h0C, 32'h0008_0000);
    idle(1);
    bus_read(8'hA0, 32'h0000_0008, "R6 low sets");
    bus_write(8'hA0, 32'h8);
    idle(1);
    bus_read(8'hA0, 32'h0000_0008, "R6 resets while low");
    check_irq(1'b1, "R11 irq stays with level");
    pins[3] = 1'b1;
    idle(1);
    clear_all();
    bus_read(8'hA0, 32'h0, "R6 high then cleared");

    // R7 high level on pin 4
    bus_write(8'h10, 32'h000C_0000);
    idle(2);
    bus_read(8'hA0, 32'h0, "R7 low no set");
    pins[4] = 1'b1;
    idle(1);
    bus_read(8'hA0, 32'h0000_0010, "R7 high sets");
    pins[4] = 1'b0;
    idle(1);
    clear_all();
    bus_read(8'hA0, 32'h0, "R7 cleared after low");

    // R8 unlisted code on pin 9, off on pin 10
    bus_write(8'h24, 32'h0005_0000);
    pins[9] = 1'b1; pins[10] = 1'b1;
    idle(2);
    pins[9] = 1'b0; pins[10] = 1'b0;
    idle(2);
    bus_read(8'hA0, 32'h0, "R8 no flag for 0x5 or 0x0");
    bus_read(8'h24, 32'h0005_0000, "R2 unlisted code stored");

    // R10 set and clear same edge on pin 0 (rising)
    pins[0] = 1'b1;
    bus_write(8'hA0, 32'h1);
    idle(1);
    bus_read(8'hA0, 32'h0000_0001, "R10 set wins");
    pins[0] = 1'b0;
    clear_all();

    // R12 zero control stops new flags, keeps existing
    pins[3] = 1'b0;
    idle(1);
    bus_write(8'h0C, 32'h0);
    idle(1);
    bus_read(8'hA0, 32'h0000_0008, "R12 flag kept");
    clear_all();
    bus_read(8'hA0, 32'h0, "R12 no new flag");
    check_irq(1'b0, "R11 irq low at end");

    idle(3);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule